// File: doc/BRIEF.md
# Subcode Serial Word Formatter

This block turns a stream of subcode symbols into framed serial words on one output line. Each accepted symbol carries seven channel bits (Q, R, S, T, U, V, W) and a flag that marks the first symbol of a subcode block. The block sends the symbol as a high start bit followed by the seven channel bits, each held for a fixed bit cell. The line rests low between words.

All timing is counted in cycles of the system clock. The bit cell and the three gap limits are given in nanoseconds and converted to cycle counts, rounded to the nearest cycle, from a clock-rate parameter in kHz. An internal symbol counter tracks the position inside a 96-symbol block. After the last symbol of a block the formatter enforces a long quiet period, so a receiver can find block boundaries from line timing alone. If the source stalls past the maximum word gap within a block, the line stays low and a one-cycle underrun pulse is raised.

Input flow uses a valid/ready handshake. Ready is withheld while a word is on the line and during the mandatory part of each gap.

Top module: `subcode_serializer`

## Requirements
- R1: Once the reset has completed, and whenever no word is being sent, `ser_out` is 0. After reset `busy` and `underrun` are 0 and `sym_ready` is 1.
- R2: A word is a start bit of value 1 followed by `sym_bits[6]` (Q), then `sym_bits[5]` down to `sym_bits[0]` (W). The first cell on the line is the start bit.
- R3: Every bit cell lasts BIT_CYC cycles, where BIT_CYC = round(CLK_KHZ * BIT_NS / 1e6), so a word occupies 8 * BIT_CYC cycles.
- R4: `sym_ready` is 0 from the cycle after an accept until the line has been low for MIN_CYC - 1 cycles. Consecutive words are separated by at least MIN_CYC low cycles (11.3 us).
- R5: If a gap that does not follow a block's last symbol reaches MAX_CYC low cycles (90 us) with no accept, the line stays low, `sym_ready` stays 1, and `underrun` is high for exactly one cycle.
- R6: After the word that is the 96th symbol of a block, `sym_ready` stays 0 until the line has been low for BLK_CYC - 1 cycles. The next word then starts no sooner than BLK_CYC low cycles (200 us) later, and no underrun is raised for that gap.
- R7: A symbol accepted with `sym_blk_start` = 1 is numbered 1, even in the middle of a block. The 96th symbol is counted from that point.
- R8: `busy` is 1 exactly during the 8 * BIT_CYC cycles of a word, starting in the cycle after the accept.
- R9: A symbol is taken only on a clock edge where `sym_valid` and `sym_ready` are both 1. Holding `sym_valid` high while `sym_ready` is 0 starts no word and does not change the line.
- R10: After reset, the first symbol accepted without `sym_blk_start` is numbered 1. Symbol numbering wraps from 96 to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sym_valid | input | 1 | A symbol is offered |
| sym_bits | input | 7 | Channel bits; bit 6 is Q, bit 0 is W |
| sym_blk_start | input | 1 | Offered symbol is the first of a subcode block |
| sym_ready | output | 1 | Formatter can take a symbol this cycle |
| ser_out | output | 1 | Serial subcode line, idle low |
| busy | output | 1 | A word is on the line |
| underrun | output | 1 | One-cycle pulse when the maximum word gap expired |

## Verification
The assertions assume that `sym_valid` is low while the internal reset synchronizer is still releasing. They also assume the source changes its inputs only between clock edges. The bench keeps `sym_valid` low for several cycles after reset and drives every input on the falling edge. To test R9, the stimulus keeps `sym_valid` high through whole words and block gaps, while the symbol bits are already changed. It deliberately stretches one gap beyond the 90 us limit inside a block, so the underrun path is taken exactly once.

// File: rtl/subcode_ser_pkg.sv
package subcode_ser_pkg;

  localparam int unsigned CH_BITS   = 7;
  localparam int unsigned WORD_BITS = CH_BITS + 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } ser_state_e;

  // nearest whole cycle for a duration in ns at a clock given in kHz
  function automatic int unsigned ns_to_cycles(input int unsigned khz, input int unsigned ns);
    longint unsigned prod;
    prod = longint'(khz) * longint'(ns) + 64'd500000;
    return int'(prod / 64'd1000000);
  endfunction

endpackage

// File: rtl/sc_word_shifter.sv
module sc_word_shifter
  import subcode_ser_pkg::*;
#(
  parameter int unsigned BIT_CYC = 113
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [WORD_BITS-1:0] load_word,
  input  logic                 run,
  output logic                 bit_o,
  output logic                 done_o
);

  localparam int unsigned BW = $clog2(BIT_CYC + 1);
  localparam int unsigned IW = $clog2(WORD_BITS + 1);

  logic [BW-1:0]        cell_q, cell_d;
  logic [IW-1:0]        idx_q, idx_d;
  logic [WORD_BITS-1:0] sh_q, sh_d;
  logic                 cell_end;
  logic                 en;

  assign cell_end = (cell_q == BW'(BIT_CYC - 1));
  assign en       = load | run;

  always_comb begin
    cell_d = cell_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    if (load) begin
      cell_d = '0;
      idx_d  = '0;
      sh_d   = load_word;
    end else if (run) begin
      if (cell_end) begin
        cell_d = '0;
        idx_d  = idx_q + IW'(1);
        sh_d   = {sh_q[WORD_BITS-2:0], 1'b0};
      end else begin
        cell_d = cell_q + BW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_q <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
    end else if (en) begin
      cell_q <= cell_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
    end
  end

  assign bit_o  = sh_q[WORD_BITS-1];
  assign done_o = run & cell_end & (idx_q == IW'(WORD_BITS - 1));

endmodule

// File: rtl/sc_gap_timer.sv
module sc_gap_timer #(
  parameter int unsigned MIN_CYC = 113,
  parameter int unsigned MAX_CYC = 900,
  parameter int unsigned BLK_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic min_o,
  output logic max_o,
  output logic blk_o
);

  localparam int unsigned LIM = (MAX_CYC > BLK_CYC) ? MAX_CYC : BLK_CYC;
  localparam int unsigned GW  = $clog2(LIM + 1);

  logic [GW-1:0] cnt_q, cnt_d;
  logic          en;

  assign en = run | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (cnt_q != GW'(LIM - 1)) begin
      cnt_d = cnt_q + GW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
    end
  end

  assign min_o = run & (cnt_q >= GW'(MIN_CYC - 1));
  assign max_o = run & (cnt_q == GW'(MAX_CYC - 1));
  assign blk_o = run & (cnt_q >= GW'(BLK_CYC - 1));

endmodule

// File: rtl/sc_sym_counter.sv
module sc_sym_counter #(
  parameter int unsigned BLOCK_LEN = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic restart,
  output logic last_o
);

  localparam int unsigned CW = $clog2(BLOCK_LEN + 1);

  logic [CW-1:0] cnt_q, cnt_nxt;

  always_comb begin
    if (restart || (cnt_q == CW'(BLOCK_LEN))) begin
      cnt_nxt = CW'(1);
    end else begin
      cnt_nxt = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign last_o = (cnt_nxt == CW'(BLOCK_LEN));

endmodule

// File: rtl/subcode_serializer.sv
module subcode_serializer
  import subcode_ser_pkg::*;
#(
  parameter int unsigned CLK_KHZ    = 10000,
  parameter int unsigned BIT_NS     = 11300,
  parameter int unsigned GAP_MIN_NS = 11300,
  parameter int unsigned GAP_MAX_NS = 90000,
  parameter int unsigned BLK_GAP_NS = 200000,
  parameter int unsigned BLOCK_LEN  = 96
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sym_valid,
  input  logic [CH_BITS-1:0] sym_bits,
  input  logic               sym_blk_start,
  output logic               sym_ready,
  output logic               ser_out,
  output logic               busy,
  output logic               underrun
);

  localparam int unsigned BIT_CYC = ns_to_cycles(CLK_KHZ, BIT_NS);
  localparam int unsigned MIN_CYC = ns_to_cycles(CLK_KHZ, GAP_MIN_NS);
  localparam int unsigned MAX_CYC = ns_to_cycles(CLK_KHZ, GAP_MAX_NS);
  localparam int unsigned BLK_CYC = ns_to_cycles(CLK_KHZ, BLK_GAP_NS);

  // reset release synchronizer
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rsync_q[1];

  ser_state_e st_q, st_d;
  logic       last_q;
  logic       under_q, under_d;
  logic       accept;
  logic       word_done, sh_bit;
  logic       gap_min, gap_max, gap_blk;
  logic       blk_last;

  assign sym_ready = rst_int_n &
                     ((st_q == ST_IDLE) |
                      ((st_q == ST_GAP) & (last_q ? gap_blk : gap_min)));
  assign accept    = sym_valid & sym_ready;

  sc_word_shifter #(
    .BIT_CYC (BIT_CYC)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load      (accept),
    .load_word ({1'b1, sym_bits}),
    .run       (st_q == ST_SEND),
    .bit_o     (sh_bit),
    .done_o    (word_done)
  );

  sc_gap_timer #(
    .MIN_CYC (MIN_CYC),
    .MAX_CYC (MAX_CYC),
    .BLK_CYC (BLK_CYC)
  ) u_gap (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (st_q == ST_GAP),
    .min_o (gap_min),
    .max_o (gap_max),
    .blk_o (gap_blk)
  );

  sc_sym_counter #(
    .BLOCK_LEN (BLOCK_LEN)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .step    (accept),
    .restart (sym_blk_start),
    .last_o  (blk_last)
  );

  always_comb begin
    st_d    = st_q;
    under_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) st_d = ST_SEND;
      end
      ST_SEND: begin
        if (word_done) st_d = ST_GAP;
      end
      ST_GAP: begin
        if (accept) begin
          st_d = ST_SEND;
        end else if (last_q) begin
          if (gap_blk) st_d = ST_IDLE;
        end else if (gap_max) begin
          st_d    = ST_IDLE;
          under_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q    <= ST_IDLE;
      last_q  <= 1'b0;
      under_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      under_q <= under_d;
      if (accept) begin
        last_q <= blk_last;
      end
    end
  end

  assign busy     = (st_q == ST_SEND);
  assign ser_out  = busy & sh_bit;
  assign underrun = under_q;

endmodule

// File: rtl/subcode_serializer_chk.sv
module subcode_serializer_chk #(
  parameter int unsigned MIN_CYC = 113
) (
  input logic clk,
  input logic rst_n,
  input logic sym_valid,
  input logic sym_ready,
  input logic busy,
  input logic ser_out,
  input logic underrun
);

  localparam int unsigned LW = $clog2(MIN_CYC + 2);

  logic [LW-1:0] lowrun_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowrun_q <= '0;
      seen_q   <= 1'b0;
    end else begin
      if (busy) begin
        lowrun_q <= '0;
        seen_q   <= 1'b1;
      end else if (lowrun_q < LW'(MIN_CYC)) begin
        lowrun_q <= lowrun_q + LW'(1);
      end
    end
  end

  assert_line_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ser_out);

  assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ser_out);

  assert_no_ready_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sym_ready);

  assert_min_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && seen_q) |-> (lowrun_q >= LW'(MIN_CYC)));

  assert_underrun_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);

  assert_underrun_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (!busy && !ser_out && sym_ready));

  assert_accept_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_ready) |=> (busy && ser_out));

  assert_word_needs_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sym_valid && sym_ready));

endmodule

bind subcode_serializer subcode_serializer_chk #(
  .MIN_CYC (MIN_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sym_valid (sym_valid),
  .sym_ready (sym_ready),
  .busy      (busy),
  .ser_out   (ser_out),
  .underrun  (underrun)
);

// File: tb/test_subcode_serializer.sv
module test_subcode_serializer;

  localparam int CLK_PERIOD = 10;
  localparam int KHZ  = 1000;
  localparam int BIT  = (KHZ * 11300 + 500000) / 1000000;
  localparam int MIN  = (KHZ * 11300 + 500000) / 1000000;
  localparam int MAX  = (KHZ * 90000 + 500000) / 1000000;
  localparam int BLK  = (KHZ * 200000 + 500000) / 1000000;
  localparam int NBLK = 96;
  localparam int WB   = 8;

  logic       clk;
  logic       rst_n;
  logic       sym_valid;
  logic [6:0] sym_bits;
  logic       sym_blk_start;
  logic       sym_ready, ser_out, busy, underrun;

  subcode_serializer #(.CLK_KHZ(KHZ)) i_subcode_serializer (
    .clk           (clk),
    .rst_n         (rst_n),
    .sym_valid     (sym_valid),
    .sym_bits      (sym_bits),
    .sym_blk_start (sym_blk_start),
    .sym_ready     (sym_ready),
    .ser_out       (ser_out),
    .busy          (busy),
    .underrun      (underrun)
  );

  int checks = 0;
  int errors = 0;
  bit run_model = 0;
  bit done = 0;

  initial clk = 0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural reference: 0 idle, 1 word, 2 gap
  int         m_mode = 0, m_t = 0, m_cnt = 0;
  bit         m_last = 0, m_under = 0;
  logic [7:0] m_word = 8'h00;
  logic [7:0] exp_words[$];
  bit         word_last[$];

  function automatic bit exp_ready();
    if (m_mode == 0) return 1'b1;
    if (m_mode == 2) return m_last ? (m_t + 1 >= BLK) : (m_t + 1 >= MIN);
    return 1'b0;
  endfunction

  function automatic bit exp_ser();
    if (m_mode != 1) return 1'b0;
    return m_word[7 - m_t / BIT];
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (run_model) begin
      bit acc;
      bit und;
      acc = sym_valid && exp_ready();
      und = 1'b0;
      if (acc) begin
        m_mode = 1;
        m_t    = 0;
        m_word = {1'b1, sym_bits};
        m_cnt  = (sym_blk_start || m_cnt == NBLK) ? 1 : m_cnt + 1;
        m_last = (m_cnt == NBLK);
        exp_words.push_back(m_word);
        word_last.push_back(m_last);
      end else if (m_mode == 1) begin
        m_t++;
        if (m_t == WB * BIT) begin
          m_mode = 2;
          m_t    = 0;
        end
      end else if (m_mode == 2) begin
        m_t++;
        if (!m_last && m_t == MAX) begin
          m_mode = 0;
          und    = 1'b1;
        end else if (m_last && m_t == BLK) begin
          m_mode = 0;
        end
      end
      m_under = und;
    end
  end

  // per-cycle compare and line monitor
  bit   prev_busy = 0, have_prev = 0, prev_last = 0, under_since = 0;
  int   lowrun = 0, under_cnt = 0, blk_gaps = 0;
  logic cap[$];

  always @(negedge clk) begin
    if (run_model) begin
      check(ser_out == exp_ser(), "R2 ser_out", ser_out, exp_ser());
      check(busy == (m_mode == 1), "R8 busy", busy, m_mode == 1);
      check(sym_ready == exp_ready(), "R4 R9 sym_ready", sym_ready, exp_ready());
      check(underrun == m_under, "R5 underrun", underrun, m_under);
      if (underrun) begin
        under_cnt++;
        under_since = 1;
      end
      if (busy) cap.push_back(ser_out);
      if (busy && !prev_busy) begin
        if (have_prev) begin
          check(lowrun >= MIN, "R4 low cycles between words", lowrun, MIN);
          if (prev_last) begin
            blk_gaps++;
            check(lowrun >= BLK, "R6 block gap low cycles", lowrun, BLK);
          end else if (!under_since) begin
            check(lowrun <= MAX, "R5 gap within maximum", lowrun, MAX);
          end
        end
        lowrun = 0;
        under_since = 0;
      end
      if (!busy) lowrun++;
      if (!busy && prev_busy) begin
        logic [7:0] w;
        logic [7:0] e;
        bit         lst;
        int         bad;
        w   = 8'h00;
        bad = 0;
        e   = (exp_words.size() > 0) ? exp_words.pop_front() : 8'h00;
        lst = (word_last.size() > 0) ? word_last.pop_front() : 1'b0;
        check(cap.size() == WB * BIT, "R3 R8 word length", cap.size(), WB * BIT);
        if (cap.size() == WB * BIT) begin
          for (int k = 0; k < WB; k++) begin
            w[7 - k] = cap[k * BIT + BIT / 2];
            for (int c = 0; c < BIT; c++)
              if (cap[k * BIT + c] !== cap[k * BIT]) bad++;
          end
        end
        check(bad == 0, "R3 bit cell held constant", bad, 0);
        check(w == e, "R2 decoded word", w, e);
        cap.delete();
        have_prev = 1;
        prev_last = lst;
      end
      prev_busy = busy;
    end
  end

  task automatic send(input logic [6:0] b, input logic bs, input int pre);
    repeat (pre) @(negedge clk);
    sym_valid     = 1'b1;
    sym_bits      = b;
    sym_blk_start = bs;
    while (!sym_ready) @(negedge clk);
    @(negedge clk);
    sym_valid     = 1'b0;
    sym_blk_start = 1'b0;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    sym_valid     = 1'b0;
    sym_bits      = 7'h00;
    sym_blk_start = 1'b0;
    rst_n         = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: state after reset
    check(ser_out == 1'b0, "R1 ser_out after reset", ser_out, 0);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(sym_ready == 1'b1, "R1 sym_ready after reset", sym_ready, 1);
    check(underrun == 1'b0, "R1 underrun after reset", underrun, 0);
    run_model = 1;

    // R10: unflagged symbols straight after reset, one late enough for an underrun (R5)
    send(7'h7F, 1'b0, 0);
    send(7'h00, 1'b0, 300);
    send(7'h55, 1'b0, 130);
    // full block from a flagged start; valid kept high during words (R9)
    send(7'h2A, 1'b1, 0);
    for (int i = 2; i <= NBLK; i++) send(7'(i * 37 + 5), 1'b0, 0);
    // first symbol of next block is offered during the block gap (R6, R9)
    send(7'h13, 1'b1, 0);
    for (int i = 2; i <= 20; i++) send(7'(i * 11 + 3), 1'b0, 0);
    // R7: resync mid-block, then 95 more symbols
    send(7'h44, 1'b1, 0);
    for (int i = 2; i <= NBLK; i++) send(7'(i * 53 + 1), 1'b0, 0);
    send(7'h3C, 1'b0, 0);
    repeat (100) @(negedge clk);

    check(under_cnt == 1, "R5 underrun pulses", under_cnt, 1);
    check(blk_gaps == 2, "R7 R10 block gaps seen", blk_gaps, 2);
    check(exp_words.size() == 0, "R8 all words sent", exp_words.size(), 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule